// File: doc/BRIEF.md
# Power-Management Event Status Pair

This block holds two byte-wide status registers for power-management events. Each implemented flag is sticky. A hardware event sets it, and only software can drop it, by writing a one into its position. The low byte records two events: a toggle of the most significant bit of the power-management timer, and a release of the global lock. The high byte records three events: a press of the power button, a real-time-clock alarm, and a power-button override caused by a long press.

A small state machine watches the debounced, active-low power switch. It counts slow ticks while the switch is held down. When the count reaches the selected long-press threshold, it raises the override flag and clears the button flag in the same cycle. The state machine has three states. `PB_RELEASED` means the switch is up. `PB_TIMING` means the switch is held and ticks are being counted. `PB_LATCHED` means the threshold has already fired for this press. The transitions are: `PB_RELEASED -> PB_TIMING` on a low switch, `PB_TIMING -> PB_RELEASED` on a high switch, `PB_TIMING -> PB_LATCHED` on the tick that reaches the threshold, and `PB_LATCHED -> PB_RELEASED` on a high switch.

The register port is byte wide and is gated by an access-enable input. Reads are combinational and have no side effects. Only the power-up reset clears the registers.

Top module: `pm1_status_regs`

## Requirements
- R1: An implemented flag goes to 1 on its hardware event. It goes to 0 only when an enabled write has a 1 in that flag's position. Writing a 0 leaves the flag unchanged.
- R2: If a hardware set and a software clear reach the same flag in the same cycle, the flag ends at 1.
- R3: Address 0 reads the low byte, with bit 0 as the timer flag and bit 5 as the lock flag. Address 1 reads the high byte, with bit 0 as the button flag, bit 2 as the alarm flag and bit 3 as the override flag. Every other bit reads 0 and cannot be written.
- R4: While `acc_en` is 0, `rdata` is 0 and writes change nothing.
- R5: The timer flag sets one clock after `tmr_msb` changes, for a rising change and for a falling change.
- R6: The lock flag sets one clock after a cycle in which `lock_rel` is 1.
- R7: The button flag sets one clock after `sw_n` goes from 1 to 0.
- R8: The alarm flag sets on every `rtc_alarm` pulse, even when it is already 1.
- R9: Once in `PB_TIMING`, a press sets the override flag and clears the button flag on its Nth tick while held. N is `THR_A` when `sel_4s` is 0 and `THR_B` when `sel_4s` is 1. A press with fewer ticks leaves the override flag at 0 and the button flag at 1.
- R10: A press fires the threshold at most once. Releasing the switch restarts the tick count.
- R11: After power-up reset (`rst_n` low), both bytes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, asynchronous, active low |
| acc_en | input | 1 | Register access enable |
| addr | input | 1 | Byte select: 0 low, 1 high |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data; a 1 clears the flag in that position |
| rdata | output | 8 | Read data of the selected byte |
| tmr_msb | input | 1 | Most significant bit of the power-management timer |
| lock_rel | input | 1 | Pulse: global lock release written with 1 |
| sw_n | input | 1 | Debounced power switch, low when pressed |
| rtc_alarm | input | 1 | Pulse: real-time-clock alarm |
| tick | input | 1 | Slow timing tick, one cycle wide |
| sel_4s | input | 1 | Long-press threshold select: 0 picks THR_A, 1 picks THR_B |

## Verification
The assertions assume that `tmr_msb` and `sw_n` are at their idle values (0 and 1) when reset is released, so that no edge is seen at startup. They also assume that `tick` is never high in the same cycle that the switch first goes low. The bench changes inputs only on falling clock edges. It holds those idle levels through reset and issues ticks only after the press has been registered. It sweeps every tick count from zero to past the larger threshold under both threshold selections.

// File: rtl/pm1_pkg.sv
package pm1_pkg;

    typedef enum logic [1:0] {
        PB_RELEASED = 2'd0,
        PB_TIMING   = 2'd1,
        PB_LATCHED  = 2'd2
    } pb_state_t;

    localparam int NFLAG = 5;
    localparam int F_TMR  = 0;
    localparam int F_LOCK = 1;
    localparam int F_BTN  = 2;
    localparam int F_RTC  = 3;
    localparam int F_OVR  = 4;

    // byte each flag lives in
    function automatic logic flag_byte(input int f);
        case (f)
            F_TMR, F_LOCK: return 1'b0;
            default:       return 1'b1;
        endcase
    endfunction

    // bit position inside its byte
    function automatic int flag_bit(input int f);
        case (f)
            F_TMR:   return 0;
            F_LOCK:  return 5;
            F_BTN:   return 0;
            F_RTC:   return 2;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/pm1_sticky_bit.sv
module pm1_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic hw_clr,
    input  logic sw_clr,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 1'b0;
        else if (hw_set)
            q <= 1'b1;
        else if (hw_clr || sw_clr)
            q <= 1'b0;
    end

    // R2
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> q);

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_set && !hw_clr && !sw_clr) |=> (q == $past(q)));

endmodule

// File: rtl/pm1_press_timer.sv
module pm1_press_timer
    import pm1_pkg::*;
#(
    parameter int THR_A = 395,
    parameter int THR_B = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_n,
    input  logic tick,
    input  logic sel_4s,
    output logic long_hit
);

    localparam int THR_MAX = (THR_A > THR_B) ? THR_A : THR_B;
    localparam int CNT_W   = $clog2(THR_MAX + 1);

    pb_state_t        state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [CNT_W-1:0] limit;

    assign limit = sel_4s ? CNT_W'(THR_B) : CNT_W'(THR_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PB_RELEASED;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        long_hit = 1'b0;
        unique case (state)
            PB_RELEASED: begin
                cnt_nx = '0;
                if (!sw_n) state_nx = PB_TIMING;
            end
            PB_TIMING: begin
                if (sw_n) begin
                    state_nx = PB_RELEASED;
                    cnt_nx   = '0;
                end else if (tick) begin
                    if (cnt + 1'b1 >= limit) begin
                        long_hit = 1'b1;
                        state_nx = PB_LATCHED;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            PB_LATCHED: begin
                cnt_nx = '0;
                if (sw_n) state_nx = PB_RELEASED;
            end
            default: state_nx = PB_RELEASED;
        endcase
    end

    // R10
    once_per_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PB_LATCHED) |-> !long_hit);

    // R9
    latch_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        long_hit |=> (state == PB_LATCHED));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PB_RELEASED) |=> (cnt == '0));

endmodule

// File: rtl/pm1_status_regs.sv
module pm1_status_regs
    import pm1_pkg::*;
#(
    parameter int THR_A = 395,
    parameter int THR_B = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_en,
    input  logic       addr,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       tmr_msb,
    input  logic       lock_rel,
    input  logic       sw_n,
    input  logic       rtc_alarm,
    input  logic       tick,
    input  logic       sel_4s
);

    logic             tmr_d1, sw_d1;
    logic             long_hit;
    logic [NFLAG-1:0] set_v, hwclr_v, swclr_v, flag;
    logic [7:0]       lo_byte, hi_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_d1 <= 1'b0;
            sw_d1  <= 1'b1;
        end else begin
            tmr_d1 <= tmr_msb;
            sw_d1  <= sw_n;
        end
    end

    pm1_press_timer #(.THR_A(THR_A), .THR_B(THR_B)) u_press (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_n     (sw_n),
        .tick     (tick),
        .sel_4s   (sel_4s),
        .long_hit (long_hit)
    );

    always_comb begin
        set_v          = '0;
        hwclr_v        = '0;
        set_v[F_TMR]   = tmr_d1 ^ tmr_msb;
        set_v[F_LOCK]  = lock_rel;
        set_v[F_BTN]   = sw_d1 & ~sw_n;
        set_v[F_RTC]   = rtc_alarm;
        set_v[F_OVR]   = long_hit;
        hwclr_v[F_BTN] = long_hit;
    end

    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
        assign swclr_v[f] = acc_en && wr_en && (addr == flag_byte(f))
                            && wdata[flag_bit(f)];
        pm1_sticky_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (set_v[f]),
            .hw_clr (hwclr_v[f]),
            .sw_clr (swclr_v[f]),
            .q      (flag[f])
        );
    end

    always_comb begin
        lo_byte = '0;
        hi_byte = '0;
        lo_byte[flag_bit(F_TMR)]  = flag[F_TMR];
        lo_byte[flag_bit(F_LOCK)] = flag[F_LOCK];
        hi_byte[flag_bit(F_BTN)]  = flag[F_BTN];
        hi_byte[flag_bit(F_RTC)]  = flag[F_RTC];
        hi_byte[flag_bit(F_OVR)]  = flag[F_OVR];
        if (!acc_en)   rdata = 8'h00;
        else if (addr) rdata = hi_byte;
        else           rdata = lo_byte;
    end

    // R4
    gate_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> (rdata == 8'h00));

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & (addr ? 8'hF2 : 8'hDE)) == 8'h00);

    // R9
    override_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        long_hit |=> (flag[F_OVR] && !flag[F_BTN]));

    // R7
    press_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_d1 && !sw_n) |=> flag[F_BTN]);

endmodule

// File: tb/pm1_status_regs_test.sv
module pm1_status_regs_test;

    localparam int TA = 5;
    localparam int TB = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0, addr = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tmr_msb = 1'b0, lock_rel = 1'b0, sw_n = 1'b1;
    logic       rtc_alarm = 1'b0, tick = 1'b0, sel_4s = 1'b0;

    int vectors = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pm1_status_regs #(.THR_A(TA), .THR_B(TB)) uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .tmr_msb(tmr_msb),
        .lock_rel(lock_rel), .sw_n(sw_n), .rtc_alarm(rtc_alarm),
        .tick(tick), .sel_4s(sel_4s)
    );

    task automatic check(input string req, input logic [7:0] got,
                         input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic rd(input logic a, input string req, input logic [7:0] exp);
        addr = a;
        #3;
        check(req, rdata, exp);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic press(input int k);
        sw_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        for (int t = 0; t < k; t++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic release_sw();
        sw_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        bad++;
        $display("FAIL watchdog: got 00 expected 01");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        acc_en = 1'b1;
        // R11 reset state
        rd(1'b0, "R11", 8'h00);
        rd(1'b1, "R11", 8'h00);

        // R5 timer flag on both edges, R1 write-one clear
        for (int n = 0; n < 4; n++) begin
            tmr_msb = ~tmr_msb;
            @(negedge clk);
            rd(1'b0, "R5", 8'h01);
            wr(1'b0, 8'hDE);
            rd(1'b0, "R1", 8'h01);
            wr(1'b0, 8'h01);
            rd(1'b0, "R1", 8'h00);
        end

        // R6 lock flag
        lock_rel = 1'b1;
        @(negedge clk);
        lock_rel = 1'b0;
        rd(1'b0, "R6", 8'h20);
        rd(1'b1, "R3", 8'h00);

        // R4 gated access
        acc_en = 1'b0;
        rd(1'b0, "R4", 8'h00);
        wr(1'b0, 8'hFF);
        acc_en = 1'b1;
        rd(1'b0, "R4", 8'h20);
        wr(1'b0, 8'hFF);
        rd(1'b0, "R3", 8'h00);

        // R8 alarm repeats; R2 set wins over clear
        for (int n = 0; n < 3; n++) begin
            rtc_alarm = 1'b1;
            @(negedge clk);
            rtc_alarm = 1'b0;
            rd(1'b1, "R8", 8'h04);
        end
        rtc_alarm = 1'b1;
        wr(1'b1, 8'h04);
        rtc_alarm = 1'b0;
        rd(1'b1, "R2", 8'h04);
        wr(1'b1, 8'h04);
        rd(1'b1, "R1", 8'h00);

        // R7/R9 sweep over tick counts and both thresholds
        for (int s = 0; s < 2; s++) begin
            sel_4s = s[0];
            for (int k = 0; k <= TB + 1; k++) begin
                int thr;
                thr = s ? TB : TA;
                press(k);
                rd(1'b1, "R9", (k >= thr) ? 8'h08 : 8'h01);
                release_sw();
                rd(1'b1, "R7", (k >= thr) ? 8'h08 : 8'h01);
                wr(1'b1, 8'hFF);
                rd(1'b1, "R1", 8'h00);
            end
        end

        // R10 fires once; release restarts the count
        sel_4s = 1'b0;
        press(TA);
        wr(1'b1, 8'h08);
        for (int t = 0; t < TA + 2; t++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
        rd(1'b1, "R10", 8'h00);
        release_sw();
        press(TA - 1);
        release_sw();
        press(1);
        rd(1'b1, "R10", 8'h01);
        release_sw();
        press(TA);
        rd(1'b1, "R10", 8'h08);
        release_sw();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end

endmodule